// File: doc/BRIEF.md
# Multi-cycle CPU bus sequencer

This block is the control state machine of a non-pipelined 32-bit RISC core that talks to memory over a Wishbone classic master port. Each instruction starts with a fetch bus cycle and then a decode cycle. The block then walks a fixed sequence of execute, memory and write-back steps that depends on the instruction's operation class. The datapath decodes the latched instruction word into a 4-bit class code and presents it during decode. It also presents the effective address, store data, access size, branch condition and jump target. The sequencer answers with one-cycle strobes that tell the datapath when to load the instruction register, advance or load the PC, capture the memory address and data registers, and write a general or special register.

The sequencer owns the program counter and the bus handshake. CYC and STB rise together only in the fetch state and in the memory state of a load or store. The slave's ACK is the only back-pressure. While STB is high and ACK is low, the machine stays in its bus state and holds every bus output unchanged. A transfer completes in the cycle where ACK is sampled high, and the strobes drop in the following state. Register-only work never touches the bus.

Top module: `cpu_seq_wbm`

## Requirements
- R1: While `rst_i` is high (synchronous), `wb_cyc_o` and `wb_stb_o` are low and `pc_o` reads 0. The first fetch after release drives address 0.
- R2: A fetch raises `wb_cyc_o`/`wb_stb_o` with `wb_we_o`=0 and all byte selects set. `ir_load_o` and `pc_inc_o` pulse in the cycle ACK is seen, and the bus strobes are low in the decode cycle that follows.
- R3: Each fetch address is the PC, which is a multiple of 4, starts at 0 and rises by 4 per completed fetch unless a jump or taken branch loads it.
- R4: Class code 0 (ALU, register or immediate) takes 2 cycles after decode: execute, then a register write (`rf_we_o`) in the second.
- R5: Class 1 (load) and class 2 (store) take 5 cycles after decode when ACK comes in the first memory cycle: address, MAR load (`mar_load_o`), memory access with CYC/STB (waits for ACK, `mdr_load_o` on ACK for a load), bus release, write-back (`rf_we_o` for a load only).
- R6: While STB is high and ACK low, the state does not advance and ADR, SEL, WE and DAT out stay unchanged.
- R7: A memory access drives the effective address with its two low bits cleared. SEL is set from the size code and those two bits: size 0 is byte (lane = addr[1:0]), size 1 is half (lanes 1:0 or 3:2 by addr[1]), and sizes 2 and 3 are word (all lanes). DAT out repeats the low byte or half across all lanes for byte and half stores.
- R8: `wb_we_o` is high only in the memory state of a store.
- R9: Class 3 (branch) takes 4 cycles after decode. `pc_load_o` pulses in the fourth only when `cond_i` is high.
- R10: Class 4 (jump) takes 2 cycles with `pc_load_o` in the second. Class 5 (jump and link) takes 3 cycles: the second writes the return address (`rf_we_o` with `link_sel_o`, while `pc_o` shows the fetch address + 4), and the third loads the PC. The new PC is the target with its low two bits cleared.
- R11: Class 6 (general to special move) takes 1 cycle with `sr_we_o`. Class 7 (special to general move) takes 1 cycle with `rf_we_o`.
- R12: Class 8 (set/compare) takes 3 cycles with `rf_we_o` in the third.
- R13: Class codes 9 to 15 return from decode straight to fetch with no strobe.
- R14: CYC/STB are never high outside fetch and the load/store memory state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| op_class_i | input | 4 | Operation class of the latched instruction, sampled in decode |
| cond_i | input | 1 | Branch condition, sampled in the last branch cycle |
| ea_i | input | AW | Effective address, captured with the MAR strobe |
| size_i | input | 2 | Access size code, captured with the MAR strobe |
| st_data_i | input | DW | Store data, captured with the MAR strobe |
| tgt_i | input | AW | Jump or branch target |
| wb_ack_i | input | 1 | Slave acknowledge |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Write enable |
| wb_adr_o | output | AW | Byte address, low two bits zero |
| wb_sel_o | output | DW/8 | Byte lane selects |
| wb_dat_o | output | DW | Write data |
| ir_load_o | output | 1 | Load instruction register |
| pc_inc_o | output | 1 | PC advance strobe |
| pc_load_o | output | 1 | PC load-from-target strobe |
| mar_load_o | output | 1 | Memory address register load |
| mdr_load_o | output | 1 | Memory data register load |
| rf_we_o | output | 1 | General register write |
| link_sel_o | output | 1 | Write-back carries the return PC |
| sr_we_o | output | 1 | Special register write |
| pc_o | output | AW | Current program counter |

## Verification
The hardest case to reach is a memory access that stalls for many cycles on a byte or half store at an odd lane. It must hold its steered address, lane selects and repeated data, and then finish on exactly the expected step. A reset that lands in the middle of an instruction is also hard to reach. The bench slave model draws a random ACK latency for every bus cycle and includes a directed twelve-cycle stall on a load. Directed byte and half stores at addresses ending in 3 and 2 reach the lane corners. Every class code from 0 to 15, including a branch with its condition low, is issued before a long random instruction stream. The stream is cut by a reset between two instructions' bus cycles.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int OCW = 4;

  localparam logic [OCW-1:0] OC_ALU    = 4'd0;
  localparam logic [OCW-1:0] OC_LOAD   = 4'd1;
  localparam logic [OCW-1:0] OC_STORE  = 4'd2;
  localparam logic [OCW-1:0] OC_BRANCH = 4'd3;
  localparam logic [OCW-1:0] OC_JUMP   = 4'd4;
  localparam logic [OCW-1:0] OC_JALR   = 4'd5;
  localparam logic [OCW-1:0] OC_MOV2S  = 4'd6;
  localparam logic [OCW-1:0] OC_MOV2G  = 4'd7;
  localparam logic [OCW-1:0] OC_SET    = 4'd8;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef enum logic [4:0] {
    ST_FETCH, ST_DECODE,
    ST_ALU_EX, ST_ALU_WB,
    ST_LS_ADDR, ST_LS_MAR, ST_LS_MEM, ST_LS_REL, ST_LS_WB,
    ST_BR_1, ST_BR_2, ST_BR_3, ST_BR_4,
    ST_J_1, ST_JL_LINK, ST_J_2,
    ST_MV,
    ST_SET_1, ST_SET_2, ST_SET_WB
  } seq_state_e;

  typedef struct packed {
    logic ir_load;
    logic pc_inc;
    logic pc_load;
    logic mar_load;
    logic mdr_load;
    logic rf_we;
    logic link_sel;
    logic sr_we;
    logic bus_req;
    logic bus_wr;
    logic fetch_ph;
  } seq_ctl_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [OCW-1:0] op_class_i,
  input  logic           ack_i,
  input  logic           cond_i,
  output seq_ctl_t       ctl_o
);
  seq_state_e     state_q, state_d;
  logic [OCW-1:0] cls_q;
  logic           is_load;

  assign is_load = (cls_q == OC_LOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FETCH;
      cls_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_DECODE) cls_q <= op_class_i;
    end
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_FETCH:   if (ack_i) state_d = ST_DECODE;
      ST_DECODE: begin
        case (op_class_i)
          OC_ALU:             state_d = ST_ALU_EX;
          OC_LOAD, OC_STORE:  state_d = ST_LS_ADDR;
          OC_BRANCH:          state_d = ST_BR_1;
          OC_JUMP, OC_JALR:   state_d = ST_J_1;
          OC_MOV2S, OC_MOV2G: state_d = ST_MV;
          OC_SET:             state_d = ST_SET_1;
          default:            state_d = ST_FETCH;
        endcase
      end
      ST_ALU_EX:  state_d = ST_ALU_WB;
      ST_ALU_WB:  state_d = ST_FETCH;
      ST_LS_ADDR: state_d = ST_LS_MAR;
      ST_LS_MAR:  state_d = ST_LS_MEM;
      ST_LS_MEM:  if (ack_i) state_d = ST_LS_REL;
      ST_LS_REL:  state_d = ST_LS_WB;
      ST_LS_WB:   state_d = ST_FETCH;
      ST_BR_1:    state_d = ST_BR_2;
      ST_BR_2:    state_d = ST_BR_3;
      ST_BR_3:    state_d = ST_BR_4;
      ST_BR_4:    state_d = ST_FETCH;
      ST_J_1:     state_d = (cls_q == OC_JALR) ? ST_JL_LINK : ST_J_2;
      ST_JL_LINK: state_d = ST_J_2;
      ST_J_2:     state_d = ST_FETCH;
      ST_MV:      state_d = ST_FETCH;
      ST_SET_1:   state_d = ST_SET_2;
      ST_SET_2:   state_d = ST_SET_WB;
      ST_SET_WB:  state_d = ST_FETCH;
      default:    state_d = ST_FETCH;
    endcase
  end

  always_comb begin
    ctl_o = '0;
    case (state_q)
      ST_FETCH: begin
        ctl_o.fetch_ph = 1'b1;
        ctl_o.bus_req  = !rst;
        ctl_o.ir_load  = ack_i && !rst;
        ctl_o.pc_inc   = ack_i && !rst;
      end
      ST_ALU_WB:  ctl_o.rf_we    = 1'b1;
      ST_LS_MAR:  ctl_o.mar_load = 1'b1;
      ST_LS_MEM: begin
        ctl_o.bus_req  = !rst;
        ctl_o.bus_wr   = (cls_q == OC_STORE) && !rst;
        ctl_o.mdr_load = ack_i && is_load && !rst;
      end
      ST_LS_WB:   ctl_o.rf_we    = is_load;
      ST_BR_4:    ctl_o.pc_load  = cond_i;
      ST_JL_LINK: begin
        ctl_o.rf_we    = 1'b1;
        ctl_o.link_sel = 1'b1;
      end
      ST_J_2:     ctl_o.pc_load  = 1'b1;
      ST_MV: begin
        ctl_o.sr_we = (cls_q == OC_MOV2S);
        ctl_o.rf_we = (cls_q == OC_MOV2G);
      end
      ST_SET_WB:  ctl_o.rf_we    = 1'b1;
      default: ;
    endcase
  end

  // R2
  fetch_release_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FETCH && ack_i) |=> !ctl_o.bus_req);

  // R6
  mem_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_o.bus_req && !ack_i) |=> ctl_o.bus_req && (state_q == $past(state_q)));

  // R14
  quiet_write_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_o.rf_we || ctl_o.sr_we || ctl_o.pc_load) |-> !ctl_o.bus_req);
endmodule

// File: rtl/seq_pc.sv
module seq_pc #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_i,
  input  logic          load_i,
  input  logic [AW-1:0] tgt_i,
  output logic [AW-1:0] pc_o
);
  localparam logic [AW-1:0] ALIGN = ~AW'(STEP - 1);
  localparam logic [AW-1:0] INCR  = AW'(STEP);

  logic [AW-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst)         pc_q <= '0;
    else if (load_i) pc_q <= tgt_i & ALIGN;
    else if (inc_i)  pc_q <= pc_q + INCR;
  end

  assign pc_o = pc_q;

  // R3
  pc_align_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_q & ~ALIGN) == '0);
endmodule

// File: rtl/seq_bus.sv
module seq_bus
  import seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fetch_ph_i,
  input  logic               bus_req_i,
  input  logic               bus_wr_i,
  input  logic               mar_load_i,
  input  logic               ack_i,
  input  logic [AW-1:0]      pc_i,
  input  logic [AW-1:0]      ea_i,
  input  logic [1:0]         size_i,
  input  logic [DW-1:0]      sdat_i,
  output logic               cyc_o,
  output logic               stb_o,
  output logic               we_o,
  output logic [AW-1:0]      adr_o,
  output logic [DW/8-1:0]    sel_o,
  output logic [DW-1:0]      dat_o
);
  localparam int NL = DW / 8;
  localparam int LB = $clog2(NL);
  localparam logic [AW-1:0] WMASK = ~AW'(NL - 1);

  logic [AW-1:0] mar_q;
  logic [1:0]    size_q;
  logic [DW-1:0] sdat_q;
  logic [DW-1:0] byte_rep, half_rep;
  logic [NL-1:0] lane;

  always_ff @(posedge clk) begin
    if (rst) begin
      mar_q  <= '0;
      size_q <= '0;
      sdat_q <= '0;
    end else if (mar_load_i) begin
      mar_q  <= ea_i;
      size_q <= size_i;
      sdat_q <= sdat_i;
    end
  end

  for (genvar g = 0; g < NL; g++) begin : g_byte
    assign byte_rep[g*8 +: 8] = sdat_q[7:0];
  end
  for (genvar h = 0; h < NL / 2; h++) begin : g_half
    assign half_rep[h*16 +: 16] = sdat_q[15:0];
  end

  always_comb begin
    case (size_q)
      SZ_BYTE: lane = NL'(1) << mar_q[LB-1:0];
      SZ_HALF: lane = NL'(3) << {mar_q[LB-1:1], 1'b0};
      default: lane = '1;
    endcase
  end

  always_comb begin
    if (fetch_ph_i) begin
      adr_o = pc_i;
      sel_o = '1;
    end else begin
      adr_o = mar_q & WMASK;
      sel_o = lane;
    end
    case (size_q)
      SZ_BYTE: dat_o = byte_rep;
      SZ_HALF: dat_o = half_rep;
      default: dat_o = sdat_q;
    endcase
  end

  assign cyc_o = bus_req_i;
  assign stb_o = bus_req_i;
  assign we_o  = bus_wr_i;

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stb_o && !ack_i) |=> stb_o && $stable(adr_o) && $stable(sel_o)
                          && $stable(we_o) && $stable(dat_o));

  // R8
  write_in_bus_chk: assert property (@(posedge clk) disable iff (rst)
    we_o |-> (stb_o && !fetch_ph_i));
endmodule

// File: rtl/cpu_seq_wbm.sv
module cpu_seq_wbm
  import seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [3:0]       op_class_i,
  input  logic             cond_i,
  input  logic [AW-1:0]    ea_i,
  input  logic [1:0]       size_i,
  input  logic [DW-1:0]    st_data_i,
  input  logic [AW-1:0]    tgt_i,
  input  logic             wb_ack_i,
  output logic             wb_cyc_o,
  output logic             wb_stb_o,
  output logic             wb_we_o,
  output logic [AW-1:0]    wb_adr_o,
  output logic [DW/8-1:0]  wb_sel_o,
  output logic [DW-1:0]    wb_dat_o,
  output logic             ir_load_o,
  output logic             pc_inc_o,
  output logic             pc_load_o,
  output logic             mar_load_o,
  output logic             mdr_load_o,
  output logic             rf_we_o,
  output logic             link_sel_o,
  output logic             sr_we_o,
  output logic [AW-1:0]    pc_o
);
  localparam int NL = DW / 8;

  seq_ctl_t      ctl;
  logic [AW-1:0] pc;

  seq_ctrl u_ctrl (
    .clk        (clk_i),
    .rst        (rst_i),
    .op_class_i (op_class_i),
    .ack_i      (wb_ack_i),
    .cond_i     (cond_i),
    .ctl_o      (ctl)
  );

  seq_pc #(.AW(AW), .STEP(NL)) u_pc (
    .clk    (clk_i),
    .rst    (rst_i),
    .inc_i  (ctl.pc_inc),
    .load_i (ctl.pc_load),
    .tgt_i  (tgt_i),
    .pc_o   (pc)
  );

  seq_bus #(.AW(AW), .DW(DW)) u_bus (
    .clk        (clk_i),
    .rst        (rst_i),
    .fetch_ph_i (ctl.fetch_ph),
    .bus_req_i  (ctl.bus_req),
    .bus_wr_i   (ctl.bus_wr),
    .mar_load_i (ctl.mar_load),
    .ack_i      (wb_ack_i),
    .pc_i       (pc),
    .ea_i       (ea_i),
    .size_i     (size_i),
    .sdat_i     (st_data_i),
    .cyc_o      (wb_cyc_o),
    .stb_o      (wb_stb_o),
    .we_o       (wb_we_o),
    .adr_o      (wb_adr_o),
    .sel_o      (wb_sel_o),
    .dat_o      (wb_dat_o)
  );

  assign ir_load_o  = ctl.ir_load;
  assign pc_inc_o   = ctl.pc_inc;
  assign pc_load_o  = ctl.pc_load;
  assign mar_load_o = ctl.mar_load;
  assign mdr_load_o = ctl.mdr_load;
  assign rf_we_o    = ctl.rf_we;
  assign link_sel_o = ctl.link_sel;
  assign sr_we_o    = ctl.sr_we;
  assign pc_o       = pc;

  // R1
  reset_pc_chk: assert property (@(posedge clk_i)
    $past(rst_i) |-> (pc_o == '0));
endmodule

// File: tb/test_cpu_seq_wbm.sv
module test_cpu_seq_wbm;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic [3:0]    op_class = '0;
  logic          cond = 1'b0;
  logic [AW-1:0] ea = '0, tgt = '0;
  logic [1:0]    size = 2'd2;
  logic [DW-1:0] sdat = '0;
  logic          ack = 1'b0;

  logic          wb_cyc_o, wb_stb_o, wb_we_o;
  logic [AW-1:0] wb_adr_o, pc_o;
  logic [3:0]    wb_sel_o;
  logic [DW-1:0] wb_dat_o;
  logic ir_load_o, pc_inc_o, pc_load_o, mar_load_o, mdr_load_o;
  logic rf_we_o, link_sel_o, sr_we_o;

  cpu_seq_wbm #(.AW(AW), .DW(DW)) i_cpu_seq_wbm (
    .clk_i(clk), .rst_i(rst), .op_class_i(op_class), .cond_i(cond),
    .ea_i(ea), .size_i(size), .st_data_i(sdat), .tgt_i(tgt),
    .wb_ack_i(ack), .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o),
    .wb_we_o(wb_we_o), .wb_adr_o(wb_adr_o), .wb_sel_o(wb_sel_o),
    .wb_dat_o(wb_dat_o), .ir_load_o(ir_load_o), .pc_inc_o(pc_inc_o),
    .pc_load_o(pc_load_o), .mar_load_o(mar_load_o),
    .mdr_load_o(mdr_load_o), .rf_we_o(rf_we_o), .link_sel_o(link_sel_o),
    .sr_we_o(sr_we_o), .pc_o(pc_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // cycles after decode for each class code
  function automatic int exp_len(input int c);
    case (c)
      0: return 2;
      1, 2: return 5;
      3: return 4;
      4: return 2;
      5: return 3;
      6, 7: return 1;
      8: return 3;
      default: return 0;
    endcase
  endfunction

  // kind: 0 rf_we, 1 pc_load, 2 sr_we, 3 mar_load, 4 bus, 5 mdr_load, 6 link
  function automatic logic [15:0] exp_mask(input int kind, input int c, input bit cnd);
    logic [15:0] m [7];
    for (int k = 0; k < 7; k++) m[k] = '0;
    case (c)
      0: m[0][2] = 1'b1;
      1: begin m[3][2] = 1'b1; m[4][3] = 1'b1; m[5][3] = 1'b1; m[0][5] = 1'b1; end
      2: begin m[3][2] = 1'b1; m[4][3] = 1'b1; end
      3: if (cnd) m[1][4] = 1'b1;
      4: m[1][2] = 1'b1;
      5: begin m[0][2] = 1'b1; m[6][2] = 1'b1; m[1][3] = 1'b1; end
      6: m[2][1] = 1'b1;
      7: m[0][1] = 1'b1;
      8: m[0][3] = 1'b1;
      default: ;
    endcase
    return m[kind];
  endfunction

  function automatic string req_of(input int c);
    case (c)
      0: return "R4 alu";
      1, 2: return "R5 load/store";
      3: return "R9 branch";
      4, 5: return "R10 jump";
      6, 7: return "R11 move";
      8: return "R12 set";
      default: return "R13 unknown class";
    endcase
  endfunction

  function automatic logic [3:0] exp_sel(input logic [1:0] sz, input logic [AW-1:0] a);
    case (sz)
      2'd0: return 4'b0001 << a[1:0];
      2'd1: return a[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [DW-1:0] exp_dat(input logic [1:0] sz, input logic [DW-1:0] d);
    case (sz)
      2'd0: return {4{d[7:0]}};
      2'd1: return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  int instr_idx = 0;
  int instr_done = 0;
  int waitn = 1;
  int cnt = 0;
  int cur_cls = 0;

  task automatic next_instr();
    ea   = $urandom;
    tgt  = $urandom;
    sdat = $urandom;
    if (instr_idx < 16) begin
      op_class = 4'(instr_idx);
      cond = 1'b1;
      size = 2'd2;
      waitn = instr_idx % 3;
    end else if (instr_idx == 16) begin
      op_class = 4'd3; cond = 1'b0; waitn = 0;
    end else if (instr_idx == 17) begin
      op_class = 4'd2; size = 2'd0; ea[1:0] = 2'b11; waitn = 2;
    end else if (instr_idx == 18) begin
      op_class = 4'd2; size = 2'd1; ea[1:0] = 2'b10; waitn = 3;
    end else if (instr_idx == 19) begin
      op_class = 4'd1; size = 2'd2; waitn = 12;
    end else begin
      op_class = ($urandom % 4 == 0) ? 4'($urandom % 16) : 4'($urandom % 9);
      cond = 1'($urandom % 2);
      size = 2'($urandom % 4);
      waitn = ($urandom % 5 == 0) ? int'($urandom % 8) : 0;
    end
    cur_cls = int'(op_class);
    instr_idx++;
  endtask

  // monitor and slave model
  int phase = 0;
  int pos = 0;
  bit first = 1'b1;
  bit mem_first = 1'b1;
  bit prev_stall = 1'b0;
  bit stall;
  logic [AW-1:0] exp_pc = '0, fetch_pc = '0, p_adr = '0;
  logic [3:0]    p_sel = '0;
  logic [DW-1:0] p_dat = '0;
  logic          p_we = 1'b0;
  logic [15:0]   gm [7];

  initial begin
    for (int k = 0; k < 7; k++) gm[k] = '0;
    forever begin
      @(negedge clk);
      if (rst) begin
        ack = 1'b0; phase = 0; first = 1'b1; exp_pc = '0;
        cnt = 0; waitn = 1; prev_stall = 1'b0;
        continue;
      end
      if (wb_stb_o) begin
        if (cnt >= waitn) ack = 1'b1;
        else begin ack = 1'b0; cnt++; end
      end else ack = 1'b0;
      #1;
      stall = wb_stb_o && !ack;
      // R8 write enable only in a store memory access
      chk(wb_we_o == (phase == 1 && wb_stb_o && cur_cls == 2), "R8 we",
          64'(wb_we_o), 64'(phase == 1 && wb_stb_o && cur_cls == 2));
      chk(wb_cyc_o == wb_stb_o, "R14 cyc/stb pair", 64'(wb_cyc_o), 64'(wb_stb_o));
      if (prev_stall && wb_stb_o) begin
        chk(wb_adr_o == p_adr && wb_sel_o == p_sel && wb_dat_o == p_dat && wb_we_o == p_we,
            "R6 hold during wait", 64'(wb_adr_o), 64'(p_adr));
      end
      if (phase == 0) begin
        chk(wb_stb_o == 1'b1, "R14 fetch strobe", 64'(wb_stb_o), 64'd1);
        if (first) begin
          chk(wb_adr_o == exp_pc, "R3 fetch address", 64'(wb_adr_o), 64'(exp_pc));
          chk(wb_sel_o == 4'hF, "R2 fetch sel", 64'(wb_sel_o), 64'hF);
          first = 1'b0;
        end
        chk(ir_load_o == ack && pc_inc_o == ack, "R2 fetch strobes",
            64'({ir_load_o, pc_inc_o}), 64'({ack, ack}));
        if (ack) begin
          fetch_pc = exp_pc;
          exp_pc = exp_pc + 32'd4;
          cnt = 0;
          next_instr();
          phase = 1; pos = 0; mem_first = 1'b1;
          for (int k = 0; k < 7; k++) gm[k] = '0;
        end
      end else begin
        if (rf_we_o)    gm[0][pos] = 1'b1;
        if (pc_load_o)  gm[1][pos] = 1'b1;
        if (sr_we_o)    gm[2][pos] = 1'b1;
        if (mar_load_o) gm[3][pos] = 1'b1;
        if (wb_stb_o)   gm[4][pos] = 1'b1;
        if (mdr_load_o) gm[5][pos] = 1'b1;
        if (link_sel_o) begin
          gm[6][pos] = 1'b1;
          chk(pc_o == fetch_pc + 32'd4, "R10 link value", 64'(pc_o), 64'(fetch_pc + 32'd4));
        end
        if (wb_stb_o && mem_first) begin
          mem_first = 1'b0;
          chk(wb_adr_o == {ea[AW-1:2], 2'b00}, "R7 mem address",
              64'(wb_adr_o), 64'({ea[AW-1:2], 2'b00}));
          chk(wb_sel_o == exp_sel(size, ea), "R7 byte select",
              64'(wb_sel_o), 64'(exp_sel(size, ea)));
          if (cur_cls == 2)
            chk(wb_dat_o == exp_dat(size, sdat), "R7 store lanes",
                64'(wb_dat_o), 64'(exp_dat(size, sdat)));
        end
        if (ack) begin
          cnt = 0;
          waitn = int'($urandom % 3);
        end
        if (!stall) begin
          if (pos >= exp_len(cur_cls)) begin
            for (int k = 0; k < 7; k++)
              chk(gm[k] == exp_mask(k, cur_cls, cond), req_of(cur_cls),
                  64'(gm[k]), 64'(exp_mask(k, cur_cls, cond)));
            if (exp_mask(1, cur_cls, cond) != '0) exp_pc = tgt & ~32'd3;
            phase = 0; first = 1'b1;
            instr_done++;
          end else if (pos < 15) pos++;
        end
      end
      prev_stall = stall;
      p_adr = wb_adr_o; p_sel = wb_sel_o; p_dat = wb_dat_o; p_we = wb_we_o;
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(posedge clk);
    #2;
    chk(!wb_cyc_o && !wb_stb_o, "R1 bus idle in reset", 64'({wb_cyc_o, wb_stb_o}), 64'd0);
    chk(pc_o == '0, "R1 pc zero", 64'(pc_o), 64'd0);
    rst = 1'b0;
    wait (instr_done >= 150);
    @(posedge clk); #2;
    rst = 1'b1;
    @(posedge clk); #2;
    chk(!wb_cyc_o && !wb_stb_o, "R1 bus idle in mid-run reset",
        64'({wb_cyc_o, wb_stb_o}), 64'd0);
    chk(pc_o == '0, "R1 pc cleared", 64'(pc_o), 64'd0);
    chk(!ir_load_o && !rf_we_o && !pc_load_o, "R1 strobes quiet",
        64'({ir_load_o, rf_we_o, pc_load_o}), 64'd0);
    rst = 1'b0;
    wait (instr_done >= 400);
    @(posedge clk); #2;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d instructions", instr_done, 400);
    finish_run();
  end
endmodule